// File: doc/BRIEF.md
# Store Write-Permission Prefetch Issuer

This block sits next to a store queue. When a store's data lands in its queue entry, it sends a request to the data cache asking for write permission on the target line, ahead of the store's commit. The request is a hint only. It expects no response, it is never retried, and the cache may refuse it without any harm. The block decides whether the hint is worth sending. It looks at the cache port budget already spent this cycle, any pending packet, the cache's blocked status, and the store's own attributes. Every request beat the cache accepts or refuses is counted.

A store marked as crossing a line boundary produces two beats. The first beat covers the bytes up to the end of the first line. The second beat covers the remainder, starting at the next line, and is sent one cycle later. The second beat goes out only if the first was accepted and the write cycle still had a spare cache port. The request port is a plain valid/ready port. A beat counts as accepted in a cycle where both valid and ready are high. A beat shown while ready is low is dropped.

Top module: `spp_issuer`

## Requirements
- R1: A store write (`st_wr_valid` high) produces a first beat in the same cycle only when `ports_used` is below `NPORTS`, `pkt_pending` is low and `cache_blocked` is low.
- R2: No beat is produced for a store write whose size is zero, or that is flagged as a data prefetch, uncacheable, or a memory-mapped internal register.
- R3: The first beat of a store that does not cross a line carries the store's address, size and queue index, with `req_hi` = 0.
- R4: For a store flagged as crossing a line (`LINE_BYTES` = 64), the first beat carries the store address with size 64 − (addr mod 64), `req_hi` = 0. One cycle later a second beat carries the next line's base address, the remaining size, the same queue index, and `req_hi` = 1.
- R5: The second beat is sent only if the first beat was accepted and `ports_used` + 1 was below `NPORTS` in the write cycle.
- R6: A beat shown while `req_ready` is low is dropped and never shown again. `cnt_dropped` rises by one on the next clock edge.
- R7: Each accepted beat raises `cnt_sent` by one on the next clock edge.
- R8: Both counters saturate at their all-ones value.
- R9: A store write that arrives in the cycle a second beat is shown gets no beat at all. The port carries the second beat in that cycle.
- R10: After synchronous reset, `req_valid` is low and both counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| st_wr_valid | input | 1 | Store data is being written this cycle |
| st_wr_addr | input | AW | Store byte address |
| st_wr_size | input | SW | Store size in bytes |
| st_wr_split | input | 1 | Store crosses a line boundary |
| st_wr_idx | input | IW | Store queue index |
| st_is_pf | input | 1 | Instruction is a data prefetch |
| st_uncached | input | 1 | Address is uncacheable |
| st_mmreg | input | 1 | Address is a memory-mapped internal register |
| ports_used | input | PUW | Cache ports already used this cycle |
| pkt_pending | input | 1 | Another packet is waiting to go to the cache |
| cache_blocked | input | 1 | Cache reports itself blocked |
| req_valid | output | 1 | Request beat valid |
| req_ready | input | 1 | Cache accepts the beat |
| req_addr | output | AW | Beat address |
| req_size | output | SW | Beat size in bytes |
| req_idx | output | IW | Store queue index of the beat |
| req_hi | output | 1 | 1 for the second (high) half of a split store |
| cnt_sent | output | CNT_W | Accepted beats, saturating |
| cnt_dropped | output | CNT_W | Refused beats, saturating |

## Verification
The first beat is combinational on the write-cycle inputs. The bench drives each store at a falling edge and samples the port one nanosecond later, inside the same cycle. The second beat is registered, so the bench samples it in the following cycle, with ready set for that beat. Each counter changes on the clock edge after the beat it counts. The bench therefore compares counters only after a further falling edge, against totals it keeps from the beats it expected. A third, idle cycle after every vector confirms that no dropped beat reappears.

// File: rtl/spp_pkg.sv
package spp_pkg;

  typedef enum logic {
    BEAT_LO = 1'b0,
    BEAT_HI = 1'b1
  } beat_e;

  // Bytes from addr up to the end of its line (line is a power of two).
  function automatic logic [63:0] bytes_to_line_end(input logic [63:0] addr,
                                                    input logic [63:0] line);
    return line - (addr & (line - 64'd1));
  endfunction

  // Base address of the line that follows the one holding addr.
  function automatic logic [63:0] next_line_base(input logic [63:0] addr,
                                                 input logic [63:0] line);
    return (addr & ~(line - 64'd1)) + line;
  endfunction

endpackage

// File: rtl/spp_gate.sv
module spp_gate #(
  parameter int NPORTS = 2,
  parameter int PUW    = 2,
  parameter int SW     = 4
) (
  input  logic           wr_valid,
  input  logic [SW-1:0]  wr_size,
  input  logic           is_pf,
  input  logic           uncached,
  input  logic           mmreg,
  input  logic [PUW-1:0] ports_used,
  input  logic           pkt_pending,
  input  logic           cache_blocked,
  input  logic           hi_busy,
  output logic           gate_ok,
  output logic           room_for_hi
);
  logic port_free;
  logic attr_ok;

  always_comb begin
    port_free   = 32'(ports_used) < 32'(NPORTS);
    room_for_hi = (32'(ports_used) + 32'd1) < 32'(NPORTS);
    attr_ok     = (wr_size != '0) && !is_pf && !uncached && !mmreg;
    gate_ok     = wr_valid && !hi_busy && port_free && !pkt_pending &&
                  !cache_blocked && attr_ok;
  end
endmodule

// File: rtl/spp_beat.sv
module spp_beat #(
  parameter int AW         = 32,
  parameter int SW         = 4,
  parameter int IW         = 4,
  parameter int LINE_BYTES = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          gate_ok,
  input  logic          room_for_hi,
  input  logic [AW-1:0] wr_addr,
  input  logic [SW-1:0] wr_size,
  input  logic          wr_split,
  input  logic [IW-1:0] wr_idx,
  input  logic          req_ready,
  output logic          req_valid,
  output logic [AW-1:0] req_addr,
  output logic [SW-1:0] req_size,
  output logic [IW-1:0] req_idx,
  output logic          req_hi,
  output logic          hi_busy,
  output logic          evt_accept,
  output logic          evt_reject
);
  import spp_pkg::*;

  localparam logic [63:0] LINE = 64'(LINE_BYTES);

  logic          hi_q;
  logic [AW-1:0] hi_addr_q;
  logic [SW-1:0] hi_size_q;
  logic [IW-1:0] hi_idx_q;
  logic [SW-1:0] lo_size;
  logic [AW-1:0] hi_addr_d;
  logic [SW-1:0] hi_size_d;
  logic          hi_arm;
  beat_e         kind;

  always_comb begin
    lo_size   = wr_split ? SW'(bytes_to_line_end(64'(wr_addr), LINE)) : wr_size;
    hi_addr_d = AW'(next_line_base(64'(wr_addr), LINE));
    hi_size_d = wr_size - lo_size;
    hi_arm    = gate_ok && wr_split && req_ready && room_for_hi;
    kind      = hi_q ? BEAT_HI : BEAT_LO;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q      <= 1'b0;
      hi_addr_q <= '0;
      hi_size_q <= '0;
      hi_idx_q  <= '0;
    end else begin
      hi_q <= hi_arm;
      if (hi_arm) begin
        hi_addr_q <= hi_addr_d;
        hi_size_q <= hi_size_d;
        hi_idx_q  <= wr_idx;
      end
    end
  end

  always_comb begin
    req_valid  = gate_ok || hi_q;
    req_hi     = (kind == BEAT_HI);
    req_addr   = hi_q ? hi_addr_q : wr_addr;
    req_size   = hi_q ? hi_size_q : lo_size;
    req_idx    = hi_q ? hi_idx_q  : wr_idx;
    hi_busy    = hi_q;
    evt_accept = req_valid && req_ready;
    evt_reject = req_valid && !req_ready;
  end
endmodule

// File: rtl/spp_evcnt.sv
module spp_evcnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)                     count <= '0;
    else if (inc && count != '1) count <= count + CNT_W'(1);
  end
endmodule

// File: rtl/spp_issuer.sv
module spp_issuer #(
  parameter int AW         = 32,
  parameter int SW         = 4,
  parameter int IW         = 4,
  parameter int NPORTS     = 2,
  parameter int LINE_BYTES = 64,
  parameter int CNT_W      = 32,
  localparam int PUW       = $clog2(NPORTS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             st_wr_valid,
  input  logic [AW-1:0]    st_wr_addr,
  input  logic [SW-1:0]    st_wr_size,
  input  logic             st_wr_split,
  input  logic [IW-1:0]    st_wr_idx,
  input  logic             st_is_pf,
  input  logic             st_uncached,
  input  logic             st_mmreg,
  input  logic [PUW-1:0]   ports_used,
  input  logic             pkt_pending,
  input  logic             cache_blocked,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [AW-1:0]    req_addr,
  output logic [SW-1:0]    req_size,
  output logic [IW-1:0]    req_idx,
  output logic             req_hi,
  output logic [CNT_W-1:0] cnt_sent,
  output logic [CNT_W-1:0] cnt_dropped
);
  logic gate_ok;
  logic room_for_hi;
  logic hi_busy;
  logic evt_accept;
  logic evt_reject;
  logic [1:0]       evt_vec;
  logic [CNT_W-1:0] cnt_vec [2];

  spp_gate #(.NPORTS(NPORTS), .PUW(PUW), .SW(SW)) gate_i (
    .wr_valid      (st_wr_valid),
    .wr_size       (st_wr_size),
    .is_pf         (st_is_pf),
    .uncached      (st_uncached),
    .mmreg         (st_mmreg),
    .ports_used    (ports_used),
    .pkt_pending   (pkt_pending),
    .cache_blocked (cache_blocked),
    .hi_busy       (hi_busy),
    .gate_ok       (gate_ok),
    .room_for_hi   (room_for_hi)
  );

  spp_beat #(.AW(AW), .SW(SW), .IW(IW), .LINE_BYTES(LINE_BYTES)) beat_i (
    .clk         (clk),
    .rst         (rst),
    .gate_ok     (gate_ok),
    .room_for_hi (room_for_hi),
    .wr_addr     (st_wr_addr),
    .wr_size     (st_wr_size),
    .wr_split    (st_wr_split),
    .wr_idx      (st_wr_idx),
    .req_ready   (req_ready),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .req_size    (req_size),
    .req_idx     (req_idx),
    .req_hi      (req_hi),
    .hi_busy     (hi_busy),
    .evt_accept  (evt_accept),
    .evt_reject  (evt_reject)
  );

  assign evt_vec = {evt_reject, evt_accept};

  for (genvar g = 0; g < 2; g++) begin : g_cnt
    spp_evcnt #(.CNT_W(CNT_W)) cnt_i (
      .clk   (clk),
      .rst   (rst),
      .inc   (evt_vec[g]),
      .count (cnt_vec[g])
    );
  end

  assign cnt_sent    = cnt_vec[0];
  assign cnt_dropped = cnt_vec[1];
endmodule

// File: rtl/spp_issuer_chk.sv
module spp_issuer_chk #(
  parameter int SW     = 4,
  parameter int IW     = 4,
  parameter int NPORTS = 2,
  parameter int PUW    = 2,
  parameter int CNT_W  = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             st_wr_valid,
  input logic [SW-1:0]    st_wr_size,
  input logic             st_wr_split,
  input logic [IW-1:0]    st_wr_idx,
  input logic             st_is_pf,
  input logic             st_uncached,
  input logic             st_mmreg,
  input logic [PUW-1:0]   ports_used,
  input logic             pkt_pending,
  input logic             cache_blocked,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_hi,
  input logic [IW-1:0]    req_idx,
  input logic             evt_accept,
  input logic             evt_reject,
  input logic [CNT_W-1:0] cnt_sent,
  input logic [CNT_W-1:0] cnt_dropped
);
  a_r1_gate: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_hi) |->
      (32'(ports_used) < 32'(NPORTS) && !pkt_pending && !cache_blocked));

  a_r2_suppress: assert property (@(posedge clk) disable iff (rst)
    (st_wr_valid && !req_hi &&
     (st_wr_size == '0 || st_is_pf || st_uncached || st_mmreg)) |-> !req_valid);

  a_r4_idx_kept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_hi) |-> (req_idx == $past(st_wr_idx)));

  a_r5_hi_after_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_hi) |->
      $past(req_valid && !req_hi && req_ready && st_wr_split &&
            (32'(ports_used) + 32'd1 < 32'(NPORTS))));

  a_r6_no_retry: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_hi) |=> !req_hi);

  a_r6_drop_count: assert property (@(posedge clk) disable iff (rst)
    (evt_reject && cnt_dropped != '1) |=> (cnt_dropped == $past(cnt_dropped) + CNT_W'(1)));

  a_r7_send_count: assert property (@(posedge clk) disable iff (rst)
    (evt_accept && cnt_sent != '1) |=> (cnt_sent == $past(cnt_sent) + CNT_W'(1)));

  a_r8_saturate: assert property (@(posedge clk) disable iff (rst)
    (cnt_sent == '1) |=> (cnt_sent == '1));
endmodule

bind spp_issuer spp_issuer_chk #(
  .SW(SW), .IW(IW), .NPORTS(NPORTS), .PUW(PUW), .CNT_W(CNT_W)
) chk_i (
  .clk           (clk),
  .rst           (rst),
  .st_wr_valid   (st_wr_valid),
  .st_wr_size    (st_wr_size),
  .st_wr_split   (st_wr_split),
  .st_wr_idx     (st_wr_idx),
  .st_is_pf      (st_is_pf),
  .st_uncached   (st_uncached),
  .st_mmreg      (st_mmreg),
  .ports_used    (ports_used),
  .pkt_pending   (pkt_pending),
  .cache_blocked (cache_blocked),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_hi        (req_hi),
  .req_idx       (req_idx),
  .evt_accept    (evt_accept),
  .evt_reject    (evt_reject),
  .cnt_sent      (cnt_sent),
  .cnt_dropped   (cnt_dropped)
);

// File: tb/spp_issuer_tb_top.sv
`timescale 1ns/1ps
module spp_issuer_tb_top;
  localparam real HALF = 2.5;

  typedef struct packed {
    logic [3:0]  rq;
    logic [31:0] addr;
    logic [3:0]  size;
    logic        split;
    logic [3:0]  idx;
    logic        pf, unc, mm;
    logic [1:0]  pused;
    logic        pend, blk, rdy_lo, rdy_hi, exp_lo, exp_hi;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [0:NV-1] = '{
    // rq  addr          sz    sp    idx   pf    unc   mm    pu    pd    bk    rl    rh    el    eh
    '{4'd3, 32'h0000_2000, 4'd4, 1'b0, 4'd3, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}, // R3
    '{4'd1, 32'h0000_2100, 4'd4, 1'b0, 4'd1, 1'b0, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R1 ports
    '{4'd1, 32'h0000_2200, 4'd4, 1'b0, 4'd2, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R1 pending
    '{4'd1, 32'h0000_2300, 4'd4, 1'b0, 4'd4, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R1 blocked
    '{4'd2, 32'h0000_2400, 4'd0, 1'b0, 4'd5, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R2 size 0
    '{4'd2, 32'h0000_2500, 4'd4, 1'b0, 4'd6, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R2 prefetch
    '{4'd2, 32'h0000_2600, 4'd4, 1'b0, 4'd7, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R2 uncached
    '{4'd2, 32'h0000_2700, 4'd4, 1'b0, 4'd8, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R2 mm reg
    '{4'd4, 32'h0000_103C, 4'd8, 1'b1, 4'd9, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1}, // R4 split
    '{4'd5, 32'h0000_10FE, 4'd4, 1'b1, 4'd10,1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}, // R5 no port
    '{4'd5, 32'h0000_117D, 4'd8, 1'b1, 4'd11,1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}, // R5 lo refused
    '{4'd6, 32'h0000_11F9, 4'd8, 1'b1, 4'd12,1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1}, // R6 hi refused
    '{4'd6, 32'h0000_2800, 4'd2, 1'b0, 4'd13,1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}  // R6 lo refused
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        st_wr_valid, st_wr_split, st_is_pf, st_uncached, st_mmreg;
  logic [31:0] st_wr_addr;
  logic [3:0]  st_wr_size, st_wr_idx;
  logic [1:0]  ports_used;
  logic        pkt_pending, cache_blocked, req_ready;
  logic        req_valid, req_hi;
  logic [31:0] req_addr;
  logic [3:0]  req_size, req_idx;
  logic [31:0] cnt_sent, cnt_dropped;
  logic        s_valid, s_hi;
  logic [31:0] s_addr;
  logic [3:0]  s_size, s_idx;
  logic [2:0]  s_sent, s_dropped;

  int errors = 0, checks = 0;
  int exp_sent = 0, exp_drop = 0;
  bit done = 0;

  always #(HALF) clk = ~clk;

  spp_issuer dut_i (
    .clk(clk), .rst(rst), .st_wr_valid(st_wr_valid), .st_wr_addr(st_wr_addr),
    .st_wr_size(st_wr_size), .st_wr_split(st_wr_split), .st_wr_idx(st_wr_idx),
    .st_is_pf(st_is_pf), .st_uncached(st_uncached), .st_mmreg(st_mmreg),
    .ports_used(ports_used), .pkt_pending(pkt_pending), .cache_blocked(cache_blocked),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_size(req_size), .req_idx(req_idx), .req_hi(req_hi),
    .cnt_sent(cnt_sent), .cnt_dropped(cnt_dropped)
  );

  spp_issuer #(.CNT_W(3)) dut_s (
    .clk(clk), .rst(rst), .st_wr_valid(st_wr_valid), .st_wr_addr(st_wr_addr),
    .st_wr_size(st_wr_size), .st_wr_split(st_wr_split), .st_wr_idx(st_wr_idx),
    .st_is_pf(st_is_pf), .st_uncached(st_uncached), .st_mmreg(st_mmreg),
    .ports_used(ports_used), .pkt_pending(pkt_pending), .cache_blocked(cache_blocked),
    .req_valid(s_valid), .req_ready(req_ready), .req_addr(s_addr),
    .req_size(s_size), .req_idx(s_idx), .req_hi(s_hi),
    .cnt_sent(s_sent), .cnt_dropped(s_dropped)
  );

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic idle_inputs();
    st_wr_valid = 0; st_wr_addr = '0; st_wr_size = '0; st_wr_split = 0;
    st_wr_idx = '0; st_is_pf = 0; st_uncached = 0; st_mmreg = 0;
    ports_used = '0; pkt_pending = 0; cache_blocked = 0; req_ready = 1;
  endtask

  task automatic plain_write(input logic [31:0] a, input logic [3:0] sz,
                             input logic [3:0] ix, input logic split);
    st_wr_valid = 1; st_wr_addr = a; st_wr_size = sz; st_wr_idx = ix;
    st_wr_split = split; st_is_pf = 0; st_uncached = 0; st_mmreg = 0;
    ports_used = 0; pkt_pending = 0; cache_blocked = 0;
  endtask

  initial begin
    #(2.0 * HALF * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    // R10: reset state
    chk("R10 req_valid", 64'(req_valid), 0);
    chk("R10 cnt_sent", 64'(cnt_sent), 0);
    chk("R10 cnt_dropped", 64'(cnt_dropped), 0);

    for (int v = 0; v < NV; v++) begin
      vec_t t;
      logic [31:0] lo_sz, hi_sz, hi_a;
      string tag;
      t = VECS[v];
      tag = $sformatf("R%0d vec%0d", t.rq, v);
      lo_sz = t.split ? (32'd64 - (t.addr % 32'd64)) : 32'(t.size);
      hi_sz = 32'(t.size) - lo_sz;
      hi_a  = (t.addr / 32'd64 + 32'd1) * 32'd64;
      @(negedge clk);
      st_wr_valid = 1; st_wr_addr = t.addr; st_wr_size = t.size;
      st_wr_split = t.split; st_wr_idx = t.idx; st_is_pf = t.pf;
      st_uncached = t.unc; st_mmreg = t.mm; ports_used = t.pused;
      pkt_pending = t.pend; cache_blocked = t.blk; req_ready = t.rdy_lo;
      #1;
      chk({tag, " lo valid"}, 64'(req_valid), 64'(t.exp_lo));
      if (t.exp_lo) begin
        chk({tag, " lo addr"}, 64'(req_addr), 64'(t.addr));
        chk({tag, " lo size"}, 64'(req_size), 64'(lo_sz));
        chk({tag, " lo idx"},  64'(req_idx),  64'(t.idx));
        chk({tag, " lo hi"},   64'(req_hi),   0);
        if (t.rdy_lo) exp_sent++; else exp_drop++;
      end
      @(negedge clk);
      idle_inputs();
      req_ready = t.rdy_hi;
      #1;
      chk({tag, " hi valid"}, 64'(req_valid), 64'(t.exp_hi));
      if (t.exp_hi) begin
        chk({tag, " hi addr"}, 64'(req_addr), 64'(hi_a));
        chk({tag, " hi size"}, 64'(req_size), 64'(hi_sz));
        chk({tag, " hi idx"},  64'(req_idx),  64'(t.idx));
        chk({tag, " hi flag"}, 64'(req_hi),   1);
        if (t.rdy_hi) exp_sent++; else exp_drop++;
      end
      @(negedge clk);
      req_ready = 1;
      #1;
      // R6: nothing reappears after a refused beat
      chk({tag, " quiet"}, 64'(req_valid), 0);
      chk("R7 cnt_sent", 64'(cnt_sent), 64'(exp_sent));
      chk("R6 cnt_dropped", 64'(cnt_dropped), 64'(exp_drop));
    end

    // R9: new write during a second beat gets nothing
    @(negedge clk);
    plain_write(32'h0000_303C, 4'd8, 4'd5, 1'b1);
    req_ready = 1;
    #1;
    chk("R9 first beat", 64'(req_valid && !req_hi), 1);
    exp_sent++;
    @(negedge clk);
    plain_write(32'h0000_4000, 4'd4, 4'd6, 1'b0);
    #1;
    chk("R9 hi flag", 64'(req_hi), 1);
    chk("R9 hi addr", 64'(req_addr), 64'h3040);
    chk("R9 hi idx", 64'(req_idx), 5);
    exp_sent++;
    @(negedge clk);
    idle_inputs();
    #1;
    chk("R9 no late beat", 64'(req_valid), 0);

    // R8: drive the narrow-counter instance into saturation
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      plain_write(32'h0000_5000 + 32'(k) * 32'd64, 4'd4, 4'(k), 1'b0);
      exp_sent++;
    end
    @(negedge clk);
    idle_inputs();
    @(negedge clk);
    #1;
    chk("R7 final cnt_sent", 64'(cnt_sent), 64'(exp_sent));
    chk("R8 sent saturates", 64'(s_sent), 64'((exp_sent > 7) ? 7 : exp_sent));
    chk("R8 dropped count", 64'(s_dropped), 64'((exp_drop > 7) ? 7 : exp_drop));

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule